// File: doc/BRIEF.md
# Event Capture and Reload Down-Counter

This block is a prescaled down-counter that measures the timing of events on two external inputs. In free-running mode the counter decrements on every prescaler tick, wraps from zero to all ones, and copies its live value into one of two holding registers whenever a qualifying edge arrives on an event input. Software reads these registers to work out periods, pulse widths or the phase between the two inputs. In reload mode, one holding register supplies the start value. A selected start event (either input or a software run command) loads the counter from it, and the counter then runs and reloads the same value each time it passes zero. Events on the capture input still store the count into the other register.

Each event input is synchronized with a two-flop chain, and a control bit per input chooses which edge counts. One control bit swaps the roles of the two inputs. A capture-valid flag reports new data and a sticky overrun flag reports a capture that arrived before software cleared the previous one. The counter output, a one-cycle zero-crossing strobe and the two flags are plain pins. The register port is a plain single-cycle write strobe with a combinational read. It has no valid/ready handshake, because no data stream crosses the block's edge and every write takes effect at once.

Top module: `evtcap_down_counter`

## Requirements
- R1: After reset the count is FFFFh, the control, reload/capture, capture and status registers read 0, and the zero strobe is low.
- R2: With the reload bit (control bit 0) clear, each cycle with `presc_tick` high decrements the count by one. A tick at 0000h gives FFFFh and raises `zero_pulse` for the one cycle after that edge.
- R3: With the reload bit set, the counter holds its value until a start event. Any write to the control register stops it again.
- R4: In reload mode, once started, a tick at 0000h loads the reload/capture register value and raises `zero_pulse`, so the zero strobe repeats every reload value + 1 ticks.
- R5: In reload mode, the start select (control bits 4:3) picks the start event: 0 = input 1, 1 = input 2, 2 = software run (write address 2 with data bit 0 set), 3 = none. A start event loads the counter from the reload/capture register.
- R6: Control bit 1 (input 1) and bit 2 (input 2) choose edge polarity: 1 = rising, 0 = falling. The opposite edge has no effect. An input change is acted on at the third clock edge after it.
- R7: The capture register (read address 2) takes the current count on every event from the capture input, whatever the reload setting. The capture input is input 1 when control bit 5 is 0 and input 2 when it is 1.
- R8: The other input's event copies the count into the reload/capture register (address 1) only while the reload bit is clear. In reload mode that event leaves the register unchanged.
- R9: Every capture into either register sets `cap_valid` (status bit 0). Writing address 2 with data bit 1 set clears it.
- R10: A capture while `cap_valid` is already set raises `cap_overrun` (status bit 1). This flag stays set until address 2 is written with data bit 2 set.
- R11: When one event both starts the counter and captures, the capture register receives the count from before the reload.
- R12: Read address 0 returns the control bits, 1 the reload/capture register, 2 the capture register, and 3 the status {overrun, valid} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 reload/capture, 2 command |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| evt1_in | input | 1 | Asynchronous event input 1 |
| evt2_in | input | 1 | Asynchronous event input 2 |
| presc_tick | input | 1 | Prescaler tick, one count per high cycle |
| count | output | 16 | Live counter value |
| zero_pulse | output | 1 | One-cycle strobe after the counter passes 0000h |
| cap_valid | output | 1 | Capture data available |
| cap_overrun | output | 1 | Sticky capture overrun |

## Verification
The embedded assertions check the following on every cycle: the per-tick decrement and the wrap to FFFFh, the hold while reload mode is waiting for a start, the reload at zero, the single-cycle edge pulse, that the capture register takes the pre-edge count, that the reload/capture register is frozen in reload mode, and that the overrun flag is sticky. The directed scenarios are the only way to show the end-to-end behaviour. These include the three-edge synchronizer latency, the full 65536-tick wrap period, each start-select choice including "none", the role swap between the inputs, and the read-out of a capture that coincides with a reload.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_CMD    = 2'd2,
    ADDR_STAT   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    START_IN1  = 2'd0,
    START_IN2  = 2'd1,
    START_SW   = 2'd2,
    START_NONE = 2'd3
  } start_sel_e;

  typedef struct packed {
    logic       cap_src;
    start_sel_e start_sel;
    logic       pol2;
    logic       pol1;
    logic       reload_en;
  } ctrl_t;

  localparam int CTRL_W        = $bits(ctrl_t);
  localparam int CMD_RUN       = 0;
  localparam int CMD_CLR_VALID = 1;
  localparam int CMD_CLR_OVR   = 2;

endpackage

// File: rtl/ctr_edge_sync.sv
module ctr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic pulse
);

  logic [STAGES-1:0] chain;
  logic              last;
  logic              synced;

  assign synced = chain[STAGES-1];

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last <= 1'b0;
    else        last <= synced;
  end

  assign pulse = rise_sel ? (synced & ~last) : (~synced & last);

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && rise_sel) |=> !(pulse && rise_sel)); // R6

endmodule

// File: rtl/ctr_down_core.sv
module ctr_down_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reload_en,
  input  logic         start,
  input  logic         stop,
  input  logic [W-1:0] rl_val,
  output logic [W-1:0] count,
  output logic         zero_pulse
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic         running;
  logic         active;
  logic         load_start;
  logic         at_zero;
  logic [W-1:0] count_nxt;
  logic         run_nxt;
  logic         zero_nxt;

  assign load_start = reload_en && start;
  assign active     = !reload_en || running;
  assign at_zero    = (count == '0);

  always_comb begin
    count_nxt = count;
    run_nxt   = running;
    zero_nxt  = 1'b0;
    if (stop) run_nxt = 1'b0;
    if (load_start) begin
      count_nxt = rl_val;
      run_nxt   = 1'b1;
    end else if (active && tick) begin
      if (at_zero) begin
        count_nxt = reload_en ? rl_val : ALL_ONES;
        zero_nxt  = 1'b1;
      end else begin
        count_nxt = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= ALL_ONES;
      running    <= 1'b0;
      zero_pulse <= 1'b0;
    end else begin
      count      <= count_nxt;
      running    <= run_nxt;
      zero_pulse <= zero_nxt;
    end
  end

  AST_FREE_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_en && tick && count != '0) |=> count == $past(count) - 1'b1); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_en && tick && count == '0) |=> (count == ALL_ONES && zero_pulse)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_en && !running && !start) |=> $stable(count)); // R3
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_en && running && !start && tick && count == '0) |=> (count == $past(rl_val) && zero_pulse)); // R4
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_en && start) |=> count == $past(rl_val)); // R5

endmodule

// File: rtl/ctr_capture_bank.sv
module ctr_capture_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_cap,
  input  logic         evt_rl,
  input  logic         reload_en,
  input  logic [W-1:0] count_i,
  input  logic         wr_rl,
  input  logic [W-1:0] wr_data,
  input  logic         clr_valid,
  input  logic         clr_ovr,
  output logic [W-1:0] rl_q,
  output logic [W-1:0] cap_q,
  output logic         valid,
  output logic         overrun
);

  logic rl_capture;
  logic any_capture;

  assign rl_capture  = evt_rl && !reload_en;
  assign any_capture = evt_cap || rl_capture;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
      rl_q  <= '0;
    end else begin
      if (evt_cap)         cap_q <= count_i;
      if (rl_capture)      rl_q  <= count_i;
      else if (wr_rl)      rl_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (any_capture)    valid <= 1'b1;
      else if (clr_valid) valid <= 1'b0;
      if (any_capture && valid && !clr_valid) overrun <= 1'b1;
      else if (clr_ovr)                       overrun <= 1'b0;
    end
  end

  AST_CAP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cap |=> cap_q == $past(count_i)); // R7
  AST_RL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_en && !wr_rl) |=> $stable(rl_q)); // R8
  AST_VALID_ON_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cap || (evt_rl && !reload_en)) |=> valid); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_ovr) |=> overrun); // R10

endmodule

// File: rtl/evtcap_down_counter.sv
module evtcap_down_counter
  import evtcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             evt1_in,
  input  logic             evt2_in,
  input  logic             presc_tick,
  output logic [CNT_W-1:0] count,
  output logic             zero_pulse,
  output logic             cap_valid,
  output logic             cap_overrun
);

  localparam int N_IN  = 2;
  localparam int PAD_C = CNT_W - CTRL_W;
  localparam int PAD_S = CNT_W - 2;

  ctrl_t           ctrl_q;
  logic [N_IN-1:0] evt_raw;
  logic [N_IN-1:0] evt_pol;
  logic [N_IN-1:0] evt;
  logic            wr_ctrl;
  logic            wr_rl;
  logic            wr_cmd;
  logic            sw_run;
  logic            clr_valid;
  logic            clr_ovr;
  logic            start;
  logic            evt_cap;
  logic            evt_rl;
  logic [CNT_W-1:0] rl_q;
  logic [CNT_W-1:0] cap_q;

  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_rl     = wr_en && (wr_addr == ADDR_RELOAD);
  assign wr_cmd    = wr_en && (wr_addr == ADDR_CMD);
  assign sw_run    = wr_cmd && wr_data[CMD_RUN];
  assign clr_valid = wr_cmd && wr_data[CMD_CLR_VALID];
  assign clr_ovr   = wr_cmd && wr_data[CMD_CLR_OVR];

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  assign evt_raw = {evt2_in, evt1_in};
  assign evt_pol = {ctrl_q.pol2, ctrl_q.pol1};

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      ctr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (evt_raw[i]),
        .rise_sel (evt_pol[i]),
        .pulse    (evt[i])
      );
    end
  endgenerate

  assign evt_cap = ctrl_q.cap_src ? evt[1] : evt[0];
  assign evt_rl  = ctrl_q.cap_src ? evt[0] : evt[1];

  always_comb begin
    unique case (ctrl_q.start_sel)
      START_IN1: start = evt[0];
      START_IN2: start = evt[1];
      START_SW:  start = sw_run;
      default:   start = 1'b0;
    endcase
  end

  ctr_down_core #(.W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (presc_tick),
    .reload_en  (ctrl_q.reload_en),
    .start      (start),
    .stop       (wr_ctrl),
    .rl_val     (rl_q),
    .count      (count),
    .zero_pulse (zero_pulse)
  );

  ctr_capture_bank #(.W(CNT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_cap   (evt_cap),
    .evt_rl    (evt_rl),
    .reload_en (ctrl_q.reload_en),
    .count_i   (count),
    .wr_rl     (wr_rl),
    .wr_data   (wr_data),
    .clr_valid (clr_valid),
    .clr_ovr   (clr_ovr),
    .rl_q      (rl_q),
    .cap_q     (cap_q),
    .valid     (cap_valid),
    .overrun   (cap_overrun)
  );

  always_comb begin
    unique case (rd_addr)
      ADDR_CTRL:   rd_data = {{PAD_C{1'b0}}, ctrl_q};
      ADDR_RELOAD: rd_data = rl_q;
      ADDR_CMD:    rd_data = cap_q;
      default:     rd_data = {{PAD_S{1'b0}}, cap_overrun, cap_valid};
    endcase
  end

  AST_ZERO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |=> !zero_pulse || count != $past(count)); // R4
  AST_NO_START_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.reload_en && ctrl_q.start_sel == START_NONE && !presc_tick && !wr_ctrl) |=> $stable(count)); // R5

endmodule

// File: tb/evtcap_down_counter_test.sv
module evtcap_down_counter_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        evt1_in = 1'b0;
  logic        evt2_in = 1'b0;
  logic        presc_tick = 1'b0;
  logic [15:0] count;
  logic        zero_pulse;
  logic        cap_valid;
  logic        cap_overrun;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evtcap_down_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt1_in(evt1_in), .evt2_in(evt2_in),
    .presc_tick(presc_tick), .count(count), .zero_pulse(zero_pulse),
    .cap_valid(cap_valid), .cap_overrun(cap_overrun)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic tick_n(input int n);
    presc_tick = 1'b1;
    repeat (n) @(negedge clk);
    presc_tick = 1'b0;
  endtask

  task automatic set_in(input int which, input logic v);
    if (which == 1) evt1_in = v; else evt2_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 count", count, 16'hFFFF);
    chk("R1 zero", {15'b0, zero_pulse}, 16'h0);
    rd_chk("R1 ctrl", 2'd0, 16'h0);
    rd_chk("R1 reload", 2'd1, 16'h0);
    rd_chk("R12 capture", 2'd2, 16'h0);
    rd_chk("R12 status", 2'd3, 16'h0);
  endtask

  task automatic t_free_run;
    tick_n(3);
    chk("R2 decrement", count, 16'hFFFC);
    chk("R2 no strobe", {15'b0, zero_pulse}, 16'h0);
    tick_n(16'hFFFC);
    chk("R2 reach zero", count, 16'h0000);
    tick_n(1);
    chk("R2 wrap", count, 16'hFFFF);
    chk("R2 strobe", {15'b0, zero_pulse}, 16'h1);
    @(negedge clk);
    chk("R2 strobe one cycle", {15'b0, zero_pulse}, 16'h0);
  endtask

  task automatic t_sw_reload;
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0011);
    rd_chk("R12 ctrl readback", 2'd0, 16'h0011);
    tick_n(4);
    chk("R3 hold before start", count, 16'hFFFF);
    wr(2'd2, 16'h0001);
    chk("R5 software start", count, 16'd5);
    tick_n(5);
    chk("R4 count to zero", count, 16'd0);
    chk("R4 no early strobe", {15'b0, zero_pulse}, 16'h0);
    tick_n(1);
    chk("R4 reload at zero", count, 16'd5);
    chk("R4 strobe", {15'b0, zero_pulse}, 16'h1);
    wr(2'd0, 16'h0019);
    wr(2'd2, 16'h0001);
    tick_n(2);
    chk("R5 select none", count, 16'd5);
  endtask

  task automatic t_in1_start;
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'd9);
    tick_n(2);
    chk("R3 hold after ctrl write", count, 16'd5);
    set_in(1, 1'b1);
    chk("R5 input1 start", count, 16'd9);
    rd_chk("R11 capture pre-reload", 2'd2, 16'd5);
    rd_chk("R9 valid set", 2'd3, 16'h1);
    set_in(1, 1'b0);
    chk("R6 falling ignored", count, 16'd9);
    tick_n(2);
    chk("R4 running", count, 16'd7);
    wr(2'd2, 16'h0002);
    rd_chk("R9 valid clear", 2'd3, 16'h0);
  endtask

  task automatic t_in2_start;
    wr(2'd0, 16'h0009);
    set_in(2, 1'b1);
    chk("R6 rising ignored", count, 16'd7);
    set_in(2, 1'b0);
    chk("R5 input2 falling start", count, 16'd9);
    rd_chk("R8 reload reg frozen", 2'd1, 16'd9);
    rd_chk("R8 no capture flag", 2'd3, 16'h0);
  endtask

  task automatic t_free_capture;
    wr(2'd0, 16'h0006);
    tick_n(1);
    chk("R2 free after reload", count, 16'd8);
    set_in(1, 1'b1);
    rd_chk("R7 capture input1", 2'd2, 16'd8);
    rd_chk("R9 valid", 2'd3, 16'h1);
    tick_n(3);
    set_in(2, 1'b1);
    rd_chk("R8 reload reg capture", 2'd1, 16'd5);
    rd_chk("R10 overrun", 2'd3, 16'h3);
    wr(2'd2, 16'h0002);
    rd_chk("R10 overrun sticky", 2'd3, 16'h2);
    wr(2'd2, 16'h0004);
    rd_chk("R10 overrun clear", 2'd3, 16'h0);
    set_in(1, 1'b0);
    set_in(2, 1'b0);
    rd_chk("R6 falling no capture", 2'd3, 16'h0);
  endtask

  task automatic t_swap;
    wr(2'd0, 16'h0026);
    tick_n(1);
    set_in(2, 1'b1);
    rd_chk("R7 capture input2", 2'd2, 16'd4);
    rd_chk("R9 valid swap", 2'd3, 16'h1);
    tick_n(1);
    set_in(1, 1'b1);
    rd_chk("R8 input1 to reload reg", 2'd1, 16'd3);
    rd_chk("R7 capture unchanged", 2'd2, 16'd4);
    rd_chk("R10 overrun swap", 2'd3, 16'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_free_run;
    t_sw_reload;
    t_in1_start;
    t_in2_start;
    t_free_capture;
    t_swap;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule